// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decoder

This block is the serial test port of a chip. It runs the standard sixteen-state test-port state machine on the test clock and holds a six-bit instruction register. It decodes the active instruction to choose which data register sits between the serial input and the serial output. The three choices are a one-bit bypass stage, a 32-bit identification word and the external boundary register. The boundary register is not part of this block. It gets capture, shift and update strobes from here, and its serial output comes back in on `bsrTdo`.

Two outputs tell the pin logic how to behave. `extestMode` makes the pins drive from the boundary register, and `globalHighZ` turns every output driver off. Both depend on a boundary-scan mode flag. That flag is set only when TMS is low at the first test-clock rising edge after the asynchronous test reset is released. The serial output changes on the falling edge of the test clock. An enable marks when that output is valid.

Top module: `tap_instr_top`

## Requirements
- R1: Asserting `trstN` low at once, without a clock, puts the port in its reset state: `tdoEn` and `tdo` low, no boundary strobe, `extestMode`, `globalHighZ` and `scanMode` low.
- R2: Whenever the state machine is in Test-Logic-Reset, the active instruction is IDCODE. Five rising edges with TMS high reach that state from any state.
- R3: In Capture-IR the instruction shift stage loads 000001. These bits leave on `tdo` least significant bit first.
- R4: BYPASS (111111) and HIGHZ (011110) select the one-bit bypass stage. It loads 0 in Capture-DR, so the data leaves one shift later than it went in.
- R5: IDCODE (000100) selects the identification word. Its bits, from bit 31 down to bit 0, are the 4-bit version parameter, the part number 1011100011011000, the maker code 00000010111 and a 1. The word leaves least significant bit first.
- R6: The active instruction changes only on the edge that leaves Update-IR, or on entry to Test-Logic-Reset. Bits shifted into the instruction stage have no effect before that edge.
- R7: Any opcode not listed in R4, R5 or R9 selects the bypass stage and asserts neither pin mode.
- R8: While HIGHZ is active and `scanMode` is high, `globalHighZ` is high.
- R9: EXTEST (011000) selects the boundary register and asserts `extestMode` when `scanMode` is high. SAMPLE/PRELOAD (011011) selects the boundary register without `extestMode`. `bsrCapture`, `bsrShift` and `bsrUpdate` are high only in Capture-DR, Shift-DR and Update-DR while the boundary register is selected. In Shift-DR, `tdo` follows `bsrTdo`.
- R10: `scanMode` is set to the inverse of TMS at the first rising edge after `trstN` is released. It then holds until the next test reset.
- R11: `tdo` and `tdoEn` change only on the falling edge of `tck`. `tdoEn` is high only when the state is Shift-IR or Shift-DR, and `tdo` is 0 when `tdoEn` is low.
- R12: In Shift-IR and Shift-DR the selected stage takes `tdi` into its most significant bit and moves toward bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| bsrTdo | input | 1 | Serial output of the external boundary register |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdoEn | output | 1 | High while `tdo` carries shifted data |
| bsrCapture | output | 1 | Boundary register capture strobe |
| bsrShift | output | 1 | Boundary register shift strobe |
| bsrUpdate | output | 1 | Boundary register update strobe |
| extestMode | output | 1 | Pins drive from the boundary register |
| globalHighZ | output | 1 | All pin output drivers disabled |
| scanMode | output | 1 | Boundary-scan mode was entered correctly |

## Verification
The bench builds the port with the version field set to 4'h5 and leaves the part number and maker code at their defaults. A nonzero version shows whether the top nibble of the identification word lands in bits 31 to 28 and is shifted out last, which an all-zero default would hide. The instruction width stays at six, so every listed opcode, plus unlisted ones such as 000000 and 101010, can be loaded. The reset-release case with TMS held high is also run, so the gating of the pin modes by `scanMode` is covered in both polarities.

// File: rtl/tap_pkg.sv
package tap_pkg;
  parameter int IR_W = 6;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  typedef struct packed {
    logic captureIr;
    logic shiftIr;
    logic captureDr;
    logic shiftDr;
    logic selId;
    logic selBsr;
  } tapStrobe_t;

  localparam logic [IR_W-1:0] OP_IDCODE = 6'b000100;
  localparam logic [IR_W-1:0] OP_BYPASS = 6'b111111;
  localparam logic [IR_W-1:0] OP_EXTEST = 6'b011000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 6'b011011;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 6'b011110;
  localparam logic [IR_W-1:0] IR_CAPTURE = 6'b000001;
endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
#(
  parameter int W = IR_W
) (
  input  logic         tck,
  input  logic         trstN,
  input  logic         tms,
  input  logic [W-1:0] irParallel,
  output tapStrobe_t   strobe,
  output logic         bsrCapture,
  output logic         bsrShift,
  output logic         bsrUpdate,
  output logic         extestMode,
  output logic         globalHighZ,
  output logic         scanMode
);
  tapState_e stateQ, nextState;
  logic [W-1:0] instrQ;
  logic armQ, scanQ;
  logic selId, selBsr;

  always_comb begin
    nextState = stateQ;
    unique case (stateQ)
      ST_TLR:    nextState = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nextState = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nextState = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nextState = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nextState = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nextState = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nextState = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nextState = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nextState = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nextState = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nextState = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nextState = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: nextState = tms ? ST_SEL_DR : ST_RTI;
      default:   nextState = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      stateQ <= ST_TLR;
      instrQ <= OP_IDCODE;
    end else begin
      stateQ <= nextState;
      if (nextState == ST_TLR) instrQ <= OP_IDCODE;
      else if (stateQ == ST_UPD_IR) instrQ <= irParallel;
    end
  end

  // boundary-scan mode entry: TMS must be low at the first edge after reset release
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      armQ  <= 1'b1;
      scanQ <= 1'b0;
    end else if (armQ) begin
      armQ  <= 1'b0;
      scanQ <= !tms;
    end
  end

  assign selId  = (instrQ == OP_IDCODE);
  assign selBsr = (instrQ == OP_EXTEST) || (instrQ == OP_SAMPLE);

  assign strobe.captureIr = (stateQ == ST_CAP_IR);
  assign strobe.shiftIr   = (stateQ == ST_SHF_IR);
  assign strobe.captureDr = (stateQ == ST_CAP_DR);
  assign strobe.shiftDr   = (stateQ == ST_SHF_DR);
  assign strobe.selId     = selId;
  assign strobe.selBsr    = selBsr;

  assign bsrCapture  = selBsr && (stateQ == ST_CAP_DR);
  assign bsrShift    = selBsr && (stateQ == ST_SHF_DR);
  assign bsrUpdate   = selBsr && (stateQ == ST_UPD_DR);
  assign extestMode  = scanQ && (instrQ == OP_EXTEST);
  assign globalHighZ = scanQ && (instrQ == OP_HIGHZ);
  assign scanMode    = scanQ;

  assert_reset_instr_R2: assert property (@(posedge tck) disable iff (!trstN)
    (stateQ == ST_TLR) |-> (instrQ == OP_IDCODE));

  assert_instr_hold_R6: assert property (@(posedge tck) disable iff (!trstN)
    (stateQ != ST_UPD_IR && nextState != ST_TLR) |=> $stable(instrQ));

  assert_scan_entry_R10: assert property (@(posedge tck) disable iff (!trstN)
    $rose(scanQ) |-> !$past(tms));

  assert_scan_hold_R10: assert property (@(posedge tck) disable iff (!trstN)
    !armQ |=> $stable(scanQ));
endmodule

// File: rtl/tap_datapath.sv
module tap_datapath
  import tap_pkg::*;
#(
  parameter int          W       = IR_W,
  parameter int          ID_W    = 32,
  parameter logic [31:0] ID_WORD = 32'h0B8D802F
) (
  input  logic         tck,
  input  logic         trstN,
  input  logic         tdi,
  input  logic         bsrTdo,
  input  tapStrobe_t   strobe,
  output logic [W-1:0] irParallel,
  output logic         tdo,
  output logic         tdoEn
);
  logic [W-1:0]    irShift;
  logic [ID_W-1:0] idShift;
  logic            bypassQ;
  logic            selBypass;
  logic            serialOut;
  logic            tdoQ, tdoEnQ;

  assign selBypass = !strobe.selId && !strobe.selBsr;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= '0;
      idShift <= '0;
      bypassQ <= 1'b0;
    end else begin
      if (strobe.captureIr) irShift <= IR_CAPTURE;
      else if (strobe.shiftIr) irShift <= {tdi, irShift[W-1:1]};

      if (strobe.selId) begin
        if (strobe.captureDr) idShift <= ID_WORD;
        else if (strobe.shiftDr) idShift <= {tdi, idShift[ID_W-1:1]};
      end

      if (selBypass) begin
        if (strobe.captureDr) bypassQ <= 1'b0;
        else if (strobe.shiftDr) bypassQ <= tdi;
      end
    end
  end

  always_comb begin
    serialOut = 1'b0;
    if (strobe.shiftIr) serialOut = irShift[0];
    else if (strobe.shiftDr) begin
      if (strobe.selId) serialOut = idShift[0];
      else if (strobe.selBsr) serialOut = bsrTdo;
      else serialOut = bypassQ;
    end
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdoQ   <= 1'b0;
      tdoEnQ <= 1'b0;
    end else begin
      tdoQ   <= serialOut;
      tdoEnQ <= strobe.shiftIr || strobe.shiftDr;
    end
  end

  assign irParallel = irShift;
  assign tdo        = tdoQ;
  assign tdoEn      = tdoEnQ;

  assert_ir_capture_R3: assert property (@(posedge tck) disable iff (!trstN)
    strobe.captureIr |=> (irShift[1:0] == 2'b01));

  assert_tdo_quiet_R11: assert property (@(posedge tck) disable iff (!trstN)
    !tdoEn |-> !tdo);

  assert_bypass_capture_R4: assert property (@(posedge tck) disable iff (!trstN)
    (strobe.captureDr && selBypass) |=> !bypassQ);
endmodule

// File: rtl/tap_instr_top.sv
module tap_instr_top
  import tap_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h0,
  parameter logic [15:0] ID_PART    = 16'hB8D8,
  parameter logic [10:0] ID_MAKER   = 11'h017
) (
  input  logic tck,
  input  logic trstN,
  input  logic tms,
  input  logic tdi,
  input  logic bsrTdo,
  output logic tdo,
  output logic tdoEn,
  output logic bsrCapture,
  output logic bsrShift,
  output logic bsrUpdate,
  output logic extestMode,
  output logic globalHighZ,
  output logic scanMode
);
  localparam logic [31:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

  tapStrobe_t      strobe;
  logic [IR_W-1:0] irParallel;

  tap_ctrl #(.W(IR_W)) ctrl_i (
    .tck(tck), .trstN(trstN), .tms(tms), .irParallel(irParallel),
    .strobe(strobe), .bsrCapture(bsrCapture), .bsrShift(bsrShift),
    .bsrUpdate(bsrUpdate), .extestMode(extestMode),
    .globalHighZ(globalHighZ), .scanMode(scanMode)
  );

  tap_datapath #(.W(IR_W), .ID_W(32), .ID_WORD(ID_WORD)) dp_i (
    .tck(tck), .trstN(trstN), .tdi(tdi), .bsrTdo(bsrTdo), .strobe(strobe),
    .irParallel(irParallel), .tdo(tdo), .tdoEn(tdoEn)
  );
endmodule

// File: tb/tap_instr_top_tb.sv
`timescale 1ns/100ps
module tap_instr_top_tb_top;
  localparam logic [31:0] EXP_ID = 32'h5B8D802F;
  // bench-side state numbering, independent of the design
  localparam int TLR = 0, RTI = 1, SDR = 2, CDR = 3, SHD = 4, E1D = 5, PD = 6, E2D = 7, UDR = 8;
  localparam int SIR = 9, CIR = 10, SHI = 11, E1I = 12, PI = 13, E2I = 14, UIR = 15;

  logic tck = 1'b0, trstN = 1'b0, tms = 1'b0, tdi = 1'b0, bsrTdo = 1'b0;
  logic tdo, tdoEn, bsrCapture, bsrShift, bsrUpdate, extestMode, globalHighZ, scanMode;

  int checks = 0, fails = 0, cycles = 0;
  int mState;
  bit [5:0] mIrSh, mInstr;
  bit mByp, mScan, mArm, bsrIn, lastTdo;
  bit [31:0] mId;
  int bsrCapSeen;

  always #2.5 tck = ~tck;

  tap_instr_top #(.ID_VERSION(4'h5)) dut_i (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .bsrTdo(bsrTdo),
    .tdo(tdo), .tdoEn(tdoEn), .bsrCapture(bsrCapture), .bsrShift(bsrShift),
    .bsrUpdate(bsrUpdate), .extestMode(extestMode), .globalHighZ(globalHighZ),
    .scanMode(scanMode));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nxt(input int s, input bit t);
    int tbl0[16] = '{RTI, RTI, CDR, SHD, SHD, PD, PD, SHD, RTI, CIR, SHI, SHI, PI, PI, SHI, RTI};
    int tbl1[16] = '{TLR, SDR, SIR, E1D, E1D, UDR, E2D, UDR, SDR, TLR, E1I, E1I, UIR, E2I, UIR, SDR};
    return t ? tbl1[s] : tbl0[s];
  endfunction

  function automatic int mSel();  // 0 bypass, 1 id, 2 boundary
    if (mInstr == 6'b000100) return 1;
    if (mInstr == 6'b011000 || mInstr == 6'b011011) return 2;
    return 0;
  endfunction

  task automatic mReset();
    mState = TLR; mInstr = 6'b000100; mIrSh = '0; mByp = 0; mId = '0; mScan = 0; mArm = 1;
  endtask

  task automatic mTick(input bit t, input bit d);
    int sel = mSel();
    if (mState == CIR) mIrSh = 6'b000001;
    else if (mState == SHI) mIrSh = {d, mIrSh[5:1]};
    if (mState == UIR) mInstr = mIrSh;
    if (mState == CDR) begin
      if (sel == 1) mId = EXP_ID;
      if (sel == 0) mByp = 0;
    end else if (mState == SHD) begin
      if (sel == 1) mId = {d, mId[31:1]};
      if (sel == 0) mByp = d;
    end
    if (mArm) begin mScan = !t; mArm = 0; end
    mState = nxt(mState, t);
    if (mState == TLR) mInstr = 6'b000100;
  endtask

  task automatic step(input bit t, input bit d);
    bit expTdo;
    int sel;
    tms = t; tdi = d; bsrTdo = bsrIn;
    @(posedge tck);
    mTick(t, d);
    #1;
    sel = mSel();
    check(bsrCapture == (mState == CDR && sel == 2), "R9 bsrCapture", bsrCapture, 0);
    check(bsrShift == (mState == SHD && sel == 2), "R9 bsrShift", bsrShift, 0);
    check(bsrUpdate == (mState == UDR && sel == 2), "R9 bsrUpdate", bsrUpdate, 0);
    check(extestMode == (mScan && mInstr == 6'b011000), "R9 extestMode", extestMode, mScan);
    check(globalHighZ == (mScan && mInstr == 6'b011110), "R8 globalHighZ", globalHighZ, mScan);
    check(scanMode == mScan, "R10 scanMode", scanMode, mScan);
    if (bsrCapture) bsrCapSeen++;
    @(negedge tck);
    #1;
    expTdo = 0;
    if (mState == SHI) expTdo = mIrSh[0];
    else if (mState == SHD) expTdo = (sel == 1) ? mId[0] : (sel == 2) ? bsrIn : mByp;
    check(tdoEn == (mState == SHI || mState == SHD), "R11 tdoEn", tdoEn, 0);
    check(tdo == expTdo, "R11/R12 tdo", tdo, expTdo);
    lastTdo = tdo;
  endtask

  task automatic loadIr(input bit [5:0] op, input bit pauseCheck, input bit hzBefore,
                        output bit [5:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    cap[0] = lastTdo;
    for (int i = 0; i < 6; i++) begin
      step(i == 5, op[i]);
      if (i < 5) cap[i+1] = lastTdo;
    end
    if (pauseCheck) begin
      step(0, 0);
      check(globalHighZ == hzBefore, "R6 instruction unchanged before update", globalHighZ, hzBefore);
      step(1, 0);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scanDr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    dout[0] = lastTdo;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      if (i < n - 1) dout[i+1] = lastTdo;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic releaseReset(input bit t);
    tms = t;
    #1 trstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge tck);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
        finishRun();
      end
    end
  end

  initial begin
    bit [5:0] cap;
    logic [63:0] dout;
    mReset();
    bsrIn = 0; bsrCapSeen = 0;
    repeat (3) @(negedge tck);
    // R1: reset state at the ports
    check(tdoEn == 0 && tdo == 0, "R1 tdo idle in reset", {tdoEn, tdo}, 0);
    check({bsrCapture, bsrShift, bsrUpdate, extestMode, globalHighZ, scanMode} == 0,
          "R1 outputs inactive in reset",
          {bsrCapture, bsrShift, bsrUpdate, extestMode, globalHighZ, scanMode}, 0);
    releaseReset(0);
    step(0, 0);
    check(scanMode == 1, "R10 scan mode entered with TMS low", scanMode, 1);

    // R5 / R2: IDCODE active after reset
    scanDr(32, 64'h0, dout);
    check(dout[31:0] == EXP_ID, "R5 identification word", dout[31:0], EXP_ID);

    // R3: instruction capture value; load BYPASS
    loadIr(6'b111111, 0, 0, cap);
    check(cap == 6'b000001, "R3 Capture-IR value", cap, 6'b000001);
    scanDr(9, 64'hA5, dout);
    check(dout[0] == 0, "R4 bypass captures zero", dout[0], 0);
    check(dout[8:1] == 8'hA5, "R4 bypass one-bit delay", dout[8:1], 8'hA5);

    // R7: unlisted opcodes decode as bypass
    loadIr(6'b000000, 0, 0, cap);
    scanDr(9, 64'h3C, dout);
    check(dout[8:0] == {8'h3C, 1'b0}, "R7 opcode 000000 bypass", dout[8:0], {8'h3C, 1'b0});
    loadIr(6'b101010, 0, 0, cap);
    check(extestMode == 0 && globalHighZ == 0, "R7 no pin mode", {extestMode, globalHighZ}, 0);
    scanDr(9, 64'h96, dout);
    check(dout[8:0] == {8'h96, 1'b0}, "R7 opcode 101010 bypass", dout[8:0], {8'h96, 1'b0});

    // R8 + R6: HIGHZ, and no effect until Update-IR
    loadIr(6'b011110, 1, 0, cap);
    check(globalHighZ == 1, "R8 HIGHZ drives global disable", globalHighZ, 1);
    scanDr(9, 64'h5A, dout);
    check(dout[8:0] == {8'h5A, 1'b0}, "R4 HIGHZ routes bypass", dout[8:0], {8'h5A, 1'b0});

    // R9: EXTEST with boundary data
    loadIr(6'b011000, 1, 1, cap);
    check(extestMode == 1 && globalHighZ == 0, "R9 EXTEST pin mode", {extestMode, globalHighZ}, 2);
    bsrIn = 1; bsrCapSeen = 0;
    scanDr(8, 64'h00, dout);
    check(dout[7:0] == 8'hFF, "R9 tdo follows boundary output", dout[7:0], 8'hFF);
    check(bsrCapSeen == 1, "R9 one boundary capture", bsrCapSeen, 1);
    bsrIn = 0;

    // R9: SAMPLE/PRELOAD selects boundary without pin mode
    loadIr(6'b011011, 0, 0, cap);
    check(extestMode == 0, "R9 SAMPLE no extest", extestMode, 0);
    bsrCapSeen = 0;
    scanDr(4, 64'hF, dout);
    check(bsrCapSeen == 1 && dout[3:0] == 4'h0, "R9 SAMPLE boundary path", dout[3:0], 0);

    // R2: five TMS-high edges reach reset and restore IDCODE
    loadIr(6'b011110, 0, 0, cap);
    repeat (5) step(1, 0);
    check(globalHighZ == 0, "R2 TMS reset clears HIGHZ", globalHighZ, 0);
    step(0, 0);
    scanDr(32, 64'h0, dout);
    check(dout[31:0] == EXP_ID, "R2 IDCODE after TMS reset", dout[31:0], EXP_ID);

    // R1: asynchronous reset in the middle of a shift
    loadIr(6'b011000, 0, 0, cap);
    step(1, 0); step(0, 0); step(0, 1); step(0, 1);
    trstN = 1'b0;
    #1;
    mReset();
    check(tdoEn == 0 && extestMode == 0 && bsrShift == 0, "R1 asynchronous reset mid-shift",
          {tdoEn, extestMode, bsrShift}, 0);
    @(negedge tck);
    // R10: TMS high at first edge blocks scan mode
    releaseReset(1);
    step(1, 0);
    check(scanMode == 0, "R10 scan mode refused with TMS high", scanMode, 0);
    step(0, 0);
    loadIr(6'b011000, 0, 0, cap);
    check(extestMode == 0, "R10 EXTEST gated without scan mode", extestMode, 0);
    loadIr(6'b011110, 0, 0, cap);
    check(globalHighZ == 0, "R10 HIGHZ gated without scan mode", globalHighZ, 0);

    finishRun();
  end
endmodule